// File: doc/BRIEF.md
# Link Interrupt Status and Forwarding Logic

This block collects interrupt sources on one side of a serial chip-to-chip bridge. Every source pulse lands in one of two bit-vector registers, chosen by a mode input. In local mode the bit goes into a status register. That register drives a one-cycle interrupt pulse toward the local interrupt controller, and a priority vector names the lowest-numbered active bit. In forward mode the bit goes into a pending register instead. Pending bits are offered to the link transmitter as an interrupt packet through a request/acknowledge handshake. The bits that were offered at the acknowledge are then retired.

Software clears status bits by writing ones to the status register. It raises pending bits by writing ones to the pending register. Both writes use a small write port with a one-bit register select. Interrupt status that arrives from the far end of the link is merged by OR into whichever register a destination-select input names; in normal use that is the pending register. Each write to the status register that leaves some status bit set fires the local interrupt again, so a pulse-sensitive controller never misses a source that is still active.

Top module: `lnk_irq_fwd`

## Requirements
- R1: With `local_mode`=1 a pulse on `src_irq[i]` sets status bit i. With `local_mode`=0 it sets pending bit i and leaves status unchanged. Either register shows the bit in the cycle after the pulse.
- R2: A write with `wr_sel`=0 (status register) clears each status bit whose `wr_data` bit is 1 and leaves the bits written with 0 unchanged.
- R3: A bit that is set by a source or by received status in the same cycle as a clear write to that bit stays set.
- R4: In local mode, when status goes from all-zero to nonzero, `irq_o` is high for exactly one cycle, in the first cycle that the nonzero status is visible.
- R5: Any status write that leaves status nonzero gives a new one-cycle `irq_o` pulse in the cycle after the write. A status write that leaves status zero gives no pulse.
- R6: `irq_o` stays low while `local_mode`=0.
- R7: A write with `wr_sel`=1 (pending register) sets each pending bit whose `wr_data` bit is 1.
- R8: `pkt_req` is high exactly while the pending register is nonzero, and it is held until `pkt_ack`. `pkt_bits` shows the pending register.
- R9: In a cycle where `pkt_ack` and `pkt_req` are both high, the pending bits shown on `pkt_bits` are cleared. Bits set in that same cycle or later stay pending.
- R10: When `rx_vld` is high, `rx_bits` is ORed into the pending register if `rx_dest`=1, or into the status register if `rx_dest`=0.
- R11: `prio_idx` gives the index of the lowest-numbered set status bit and `prio_any` shows that any status bit is set. With status zero, both are 0.
- R12: After reset, status, pending, `irq_o`, `pkt_req`, `prio_any` and `prio_idx` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_mode | input | 1 | 1: sources go to status and local pulse; 0: sources go to pending for forwarding |
| src_irq | input | NSRC | Interrupt source pulses, one per bit |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = status (write-one-to-clear), 1 = pending (write-one-to-set) |
| wr_data | input | NSRC | Write data |
| rx_vld | input | 1 | Received remote interrupt status is valid |
| rx_dest | input | 1 | Destination of received status: 1 = pending, 0 = status |
| rx_bits | input | NSRC | Received remote interrupt status |
| pkt_ack | input | 1 | Transmitter has taken the interrupt packet |
| pkt_req | output | 1 | Interrupt packet requested |
| pkt_bits | output | NSRC | Pending bits offered in the packet |
| status_o | output | NSRC | Status register |
| pend_o | output | NSRC | Pending register |
| irq_o | output | 1 | Local interrupt pulse |
| prio_any | output | 1 | Some status bit is set |
| prio_idx | output | IDXW | Index of the lowest set status bit |

## Verification
The bench builds the block with the default NSRC of 32 and a 5-bit priority index. This puts both ends of the vector within reach: bit 0, bit 31, and the top bit of the received status words. The priority encoder is driven with bits 12 and 31 set together, so both its shortest and its longest search paths are exercised. With 32 sources, a source pulse and a clear can also hit the same bit in the same cycle while other bits stay set. The same holds for an acknowledge and a new set in one cycle, which shows that acknowledge retires only the bits it captured.

// File: rtl/lnk_irq_fwd_pkg.sv
package lnk_irq_fwd_pkg;

   // register / destination select encoding shared by write port and receive path
   typedef enum logic {
      SEL_STATUS  = 1'b0,
      SEL_PENDING = 1'b1
   } irq_sel_e;

endpackage

// File: rtl/lnk_irq_prienc.sv
// Lowest-index-first priority encoder over the status vector.
module lnk_irq_prienc #(
   parameter int NSRC = 32,
   localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] vec,
   output logic            any,
   output logic [IDXW-1:0] idx
);

   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (vec[i]) begin
            any = 1'b1;
            idx = IDXW'(i);
         end
      end
   end

   // R11
   prio_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> vec[idx]);

   // R11
   prio_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> ((vec & ~({NSRC{1'b1}} << idx)) == '0));

   // R11
   prio_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vec == '0) |-> (!any && idx == '0));

endmodule

// File: rtl/lnk_irq_status.sv
// Status register (set / write-one-to-clear) and local interrupt pulse.
module lnk_irq_status #(
   parameter int NSRC = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            local_mode,
   input  logic [NSRC-1:0] set_mask,
   input  logic            clr_wr,
   input  logic [NSRC-1:0] clr_mask,
   output logic [NSRC-1:0] status_q,
   output logic            irq_o
);

   logic [NSRC-1:0] status_d;
   logic            fire;

   always_comb begin
      status_d = (status_q & ~clr_mask) | set_mask;
      fire     = local_mode && (status_d != '0) &&
                 ((status_q == '0) || clr_wr);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= '0;
         irq_o    <= 1'b0;
      end else begin
         status_q <= status_d;
         irq_o    <= fire;
      end
   end

   // R2
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> ((status_q & $past(clr_mask & ~set_mask)) == '0));

   // R3
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_mask != '0) |=> ((status_q & $past(set_mask)) == $past(set_mask)));

   // R4
   irq_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (status_q != '0));

   // R4
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !clr_wr) |=> !irq_o);

   // R6
   irq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !local_mode |=> !irq_o);

endmodule

// File: rtl/lnk_irq_pending.sv
// Pending register (write-one-to-set) with packet request/acknowledge.
module lnk_irq_pending #(
   parameter int NSRC = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_mask,
   input  logic            pkt_ack,
   output logic            pkt_req,
   output logic [NSRC-1:0] pend_q
);

   logic [NSRC-1:0] retire;
   logic [NSRC-1:0] pend_d;

   always_comb begin
      pkt_req = (pend_q != '0);
      retire  = (pkt_ack && pkt_req) ? pend_q : '0;
      pend_d  = (pend_q & ~retire) | set_mask;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end

   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_req && !pkt_ack) |=> pkt_req);

   // R9
   ack_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_req && pkt_ack) |=> ((pend_q & ~$past(set_mask)) == '0));

   // R9
   pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_mask != '0) |=> ((pend_q & $past(set_mask)) == $past(set_mask)));

endmodule

// File: rtl/lnk_irq_fwd.sv
module lnk_irq_fwd
   import lnk_irq_fwd_pkg::*;
#(
   parameter int NSRC = 32,
   localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            local_mode,
   input  logic [NSRC-1:0] src_irq,
   input  logic            wr_en,
   input  logic            wr_sel,
   input  logic [NSRC-1:0] wr_data,
   input  logic            rx_vld,
   input  logic            rx_dest,
   input  logic [NSRC-1:0] rx_bits,
   input  logic            pkt_ack,
   output logic            pkt_req,
   output logic [NSRC-1:0] pkt_bits,
   output logic [NSRC-1:0] status_o,
   output logic [NSRC-1:0] pend_o,
   output logic            irq_o,
   output logic            prio_any,
   output logic [IDXW-1:0] prio_idx
);

   generate
      if (NSRC < 2 || NSRC > 1024) begin : g_bad_nsrc
         $error("lnk_irq_fwd: NSRC must lie in 2..1024");
      end
   endgenerate

   logic            stat_wr;
   logic [NSRC-1:0] stat_set;
   logic [NSRC-1:0] stat_clr;
   logic [NSRC-1:0] pend_set;
   logic            rx_to_stat;
   logic            rx_to_pend;

   always_comb begin
      stat_wr    = wr_en && (wr_sel == SEL_STATUS);
      rx_to_stat = rx_vld && (rx_dest == SEL_STATUS);
      rx_to_pend = rx_vld && (rx_dest == SEL_PENDING);
      stat_clr   = stat_wr ? wr_data : '0;
      stat_set   = (local_mode ? src_irq : '0) |
                   (rx_to_stat ? rx_bits : '0);
      pend_set   = (local_mode ? '0 : src_irq) |
                   (rx_to_pend ? rx_bits : '0) |
                   ((wr_en && wr_sel == SEL_PENDING) ? wr_data : '0);
   end

   lnk_irq_status #(.NSRC(NSRC)) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .local_mode (local_mode),
      .set_mask   (stat_set),
      .clr_wr     (stat_wr),
      .clr_mask   (stat_clr),
      .status_q   (status_o),
      .irq_o      (irq_o)
   );

   lnk_irq_pending #(.NSRC(NSRC)) u_pending (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_mask (pend_set),
      .pkt_ack  (pkt_ack),
      .pkt_req  (pkt_req),
      .pend_q   (pend_o)
   );

   lnk_irq_prienc #(.NSRC(NSRC)) u_prio (
      .clk   (clk),
      .rst_n (rst_n),
      .vec   (status_o),
      .any   (prio_any),
      .idx   (prio_idx)
   );

   assign pkt_bits = pend_o;

   // R1
   fwd_no_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!local_mode && !rx_to_stat) |=> ($past(status_o) & ~status_o) == $past(status_o & stat_clr) && (status_o & ~$past(status_o)) == '0);

   // R10
   rx_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_to_pend |=> ((pend_o & $past(rx_bits)) == $past(rx_bits)));

endmodule

// File: tb/test_lnk_irq_fwd.sv
module test_lnk_irq_fwd;

   localparam int NSRC = 32;
   localparam int IDXW = 5;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            local_mode;
   logic [NSRC-1:0] src_irq;
   logic            wr_en;
   logic            wr_sel;
   logic [NSRC-1:0] wr_data;
   logic            rx_vld;
   logic            rx_dest;
   logic [NSRC-1:0] rx_bits;
   logic            pkt_ack;
   logic            pkt_req;
   logic [NSRC-1:0] pkt_bits;
   logic [NSRC-1:0] status_o;
   logic [NSRC-1:0] pend_o;
   logic            irq_o;
   logic            prio_any;
   logic [IDXW-1:0] prio_idx;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   lnk_irq_fwd #(.NSRC(NSRC)) i_lnk_irq_fwd (
      .clk(clk), .rst_n(rst_n), .local_mode(local_mode), .src_irq(src_irq),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rx_vld(rx_vld), .rx_dest(rx_dest), .rx_bits(rx_bits),
      .pkt_ack(pkt_ack), .pkt_req(pkt_req), .pkt_bits(pkt_bits),
      .status_o(status_o), .pend_o(pend_o), .irq_o(irq_o),
      .prio_any(prio_any), .prio_idx(prio_idx)
   );

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      src_irq = '0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
      rx_vld = 1'b0; rx_dest = 1'b0; rx_bits = '0; pkt_ack = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; local_mode = 1'b1; idle_inputs();
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
   endtask

   task automatic t_reset();
      do_reset();
      chk("R12 status", status_o, 0);
      chk("R12 pending", pend_o, 0);
      chk("R12 irq", irq_o, 0);
      chk("R12 pkt_req", pkt_req, 0);
      chk("R12 prio_any", prio_any, 0);
      chk("R12 prio_idx", prio_idx, 0);
   endtask

   task automatic t_local_pulse();
      do_reset();
      src_irq = 32'h0000_0010;
      cyc(); idle_inputs();
      chk("R1 status set", status_o, 32'h10);
      chk("R1 pending untouched", pend_o, 0);
      chk("R4 irq first cycle", irq_o, 1);
      cyc();
      chk("R4 irq one cycle", irq_o, 0);
      src_irq = 32'h0000_0006;
      cyc(); idle_inputs();
      chk("R4 no pulse when already nonzero", irq_o, 0);
      chk("R1 status accumulates", status_o, 32'h16);
   endtask

   task automatic t_w1c_refire();
      wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0000_0012;
      cyc(); idle_inputs();
      chk("R2 w1c partial", status_o, 32'h4);
      chk("R5 refire", irq_o, 1);
      cyc();
      chk("R5 refire one cycle", irq_o, 0);
      wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0000_0004;
      cyc(); idle_inputs();
      chk("R2 w1c last", status_o, 0);
      chk("R5 no pulse on empty", irq_o, 0);
   endtask

   task automatic t_set_wins();
      src_irq = 32'h0000_0081;
      cyc(); idle_inputs(); cyc();
      wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0000_0081;
      src_irq = 32'h0000_0080;
      cyc(); idle_inputs();
      chk("R3 set beats clear", status_o, 32'h80);
      wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h80;
      cyc(); idle_inputs();
   endtask

   task automatic t_forward();
      do_reset();
      local_mode = 1'b0;
      cyc();
      src_irq = 32'h0000_0200;
      cyc(); idle_inputs();
      chk("R1 forward to pending", pend_o, 32'h200);
      chk("R1 forward leaves status", status_o, 0);
      chk("R6 no irq forward", irq_o, 0);
      chk("R8 req raised", pkt_req, 1);
      chk("R8 bits shown", pkt_bits, 32'h200);
      repeat (3) cyc();
      chk("R8 req held", pkt_req, 1);
      wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'h8000_0001;
      cyc(); idle_inputs();
      chk("R7 pending set", pend_o, 32'h8000_0201);
      pkt_ack = 1'b1; src_irq = 32'h0000_0020;
      cyc(); idle_inputs();
      chk("R9 late set kept", pend_o, 32'h20);
      chk("R9 req stays", pkt_req, 1);
      pkt_ack = 1'b1;
      cyc(); idle_inputs();
      chk("R9 retire all", pend_o, 0);
      chk("R8 req drops", pkt_req, 0);
   endtask

   task automatic t_rx();
      do_reset();
      local_mode = 1'b0;
      rx_vld = 1'b1; rx_dest = 1'b1; rx_bits = 32'hA500_0000;
      cyc(); idle_inputs();
      chk("R10 rx to pending", pend_o, 32'hA500_0000);
      chk("R10 rx pending leaves status", status_o, 0);
      rx_vld = 1'b1; rx_dest = 1'b0; rx_bits = 32'h0000_0300;
      cyc(); idle_inputs();
      chk("R10 rx to status", status_o, 32'h300);
      chk("R10 rx status leaves pending", pend_o, 32'hA500_0000);
   endtask

   task automatic t_prio();
      do_reset();
      src_irq = 32'h8000_1000;
      cyc(); idle_inputs();
      chk("R11 any", prio_any, 1);
      chk("R11 lowest", prio_idx, 12);
      wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0000_1000;
      cyc(); idle_inputs();
      chk("R11 top bit", prio_idx, 31);
      wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h8000_0000;
      cyc(); idle_inputs();
      chk("R11 none any", prio_any, 0);
      chk("R11 none idx", prio_idx, 0);
      src_irq = 32'h0000_0001;
      cyc(); idle_inputs();
      chk("R11 bit zero", {prio_any, prio_idx}, {1'b1, 5'd0});
   endtask

   initial begin
      t_reset();
      t_local_pulse();
      t_w1c_refire();
      t_set_wins();
      t_forward();
      t_rx();
      t_prio();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule